// File: doc/BRIEF.md
# Stream-to-Memory Unpacking DMA

This block moves a programmed number of wide stream beats into memory. Each beat carries several fixed-point elements. The block takes one beat from a valid/ready stream sink and holds it in a single beat buffer. It then issues one write per element through a write-only memory port that honours wait-request. Each element goes to the next consecutive address. Before it is written, each element is rescaled from its stream fixed-point format to the memory word format.

Software-side control is a start pulse that carries a base address and a beat count. The transfer ends on the count alone. Start-of-packet and end-of-packet markers on the stream are accepted but do nothing. A sticky done flag reports that the last element write was accepted. The flag stays set until the next accepted start.

Top module: `s2m_unpack_dma`

## Requirements
- R1: While reset is asserted and right after it, `s_ready`, `m_write` and `done` are 0.
- R2: A start pulse is accepted only while the block is idle. From the following cycle, `s_ready` is 1 while no beat is held. `s_ready` is 0 for as long as the elements of the held beat are being written, so `s_ready` and `m_write` are never both 1.
- R3: Exactly `cfg_beats` beats are accepted per transfer. After the last beat, `s_ready` stays 0 and no further writes are issued.
- R4: Element j of a beat occupies bits [j*ELEM_W +: ELEM_W] of `s_data`. Element j of beat i is written to address `cfg_base + i*N_ELEM + j`. Elements within a beat are written in ascending j order.
- R5: An element is read as a two's-complement value with ELEM_FRAC fraction bits. It is shifted arithmetically by MEM_FRAC-ELEM_FRAC bits (left if positive, right with floor if negative), and its low MEM_W bits are written. With the defaults, this is an arithmetic right shift by 2.
- R6: While `m_write` is 1 and `m_waitreq` is 1, the write is not taken. `m_write`, `m_addr` and `m_wdata` hold their values into the next cycle.
- R7: `done` rises in the cycle after the final element write is accepted (`m_write` high with `m_waitreq` low). It stays high until a new start is accepted, and it reads 0 in the cycle after that start.
- R8: `s_sop` and `s_eop` have no effect. An early end-of-packet marker does not end the transfer, and a missing one does not stall it.
- R9: A start with `cfg_beats` equal to 0 sets `done` in the next cycle. No beat is accepted and no write is issued.
- R10: A start pulse during a transfer is ignored. Addresses and the beat count of the running transfer are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Start pulse; loads base and count when idle |
| cfg_base | input | ADDR_W | First memory word address |
| cfg_beats | input | CNT_W | Number of stream beats to move |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Stream ready (zero ready latency) |
| s_data | input | N_ELEM*ELEM_W | Packed fixed-point elements, element 0 in the low bits |
| s_sop | input | 1 | Start-of-packet marker (ignored) |
| s_eop | input | 1 | End-of-packet marker (ignored) |
| m_write | output | 1 | Memory write request |
| m_addr | output | ADDR_W | Memory word address |
| m_wdata | output | MEM_W | Converted element |
| m_waitreq | input | 1 | Memory stall; holds the current write |
| done | output | 1 | Sticky transfer-complete flag |

## Verification
The bench sends elements at the conversion extremes: the most positive and most negative codes, minus one, and small values whose fraction is lost in the shift. A converter that shifted logically or picked the wrong bits would write wrong words for the negative values. Wait-request is applied in pseudo-random bursts, including on the final write. A design that advanced its element index or address during a stall would skip or repeat an address, and one that raised done too early would show done while the last write was still stalled. Transfers are run with an eop on the first beat, with no markers at all, with a zero count, and with a second start in mid-transfer. A design that stopped on eop, hung waiting for one, or reloaded its base would fail the address scoreboard or never finish.

// File: rtl/s2m_pkg.sv
package s2m_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RECV  = 2'd1,
    ST_WRITE = 2'd2
  } s2m_state_e;
endpackage

// File: rtl/s2m_elem_conv.sv
// Fixed-point rescale of one stream element into a memory word.
module s2m_elem_conv #(
  parameter int ELEM_W    = 18,
  parameter int ELEM_FRAC = 10,
  parameter int MEM_W     = 16,
  parameter int MEM_FRAC  = 8
) (
  input  logic [ELEM_W-1:0] elem_in,
  output logic [MEM_W-1:0]  word_out
);
  localparam int SHL   = (MEM_FRAC >= ELEM_FRAC) ? (MEM_FRAC - ELEM_FRAC) : 0;
  localparam int SHR   = (MEM_FRAC <  ELEM_FRAC) ? (ELEM_FRAC - MEM_FRAC) : 0;
  localparam int WIDE  = ELEM_W + MEM_W + SHL + 1;

  logic signed [WIDE-1:0] ext;
  logic signed [WIDE-1:0] scaled;

  always_comb begin
    ext = {{(WIDE-ELEM_W){elem_in[ELEM_W-1]}}, elem_in};
  end

  generate
    if (MEM_FRAC >= ELEM_FRAC) begin : g_up
      always_comb scaled = ext <<< SHL;
    end else begin : g_down
      always_comb scaled = ext >>> SHR;
    end
  endgenerate

  assign word_out = scaled[MEM_W-1:0];
endmodule

// File: rtl/s2m_beat_buf.sv
// Single-beat holding register with element selection.
module s2m_beat_buf #(
  parameter int ELEM_W = 18,
  parameter int N_ELEM = 4,
  localparam int SEL_W = (N_ELEM > 1) ? $clog2(N_ELEM) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [N_ELEM*ELEM_W-1:0] din,
  input  logic [SEL_W-1:0]         sel,
  output logic [ELEM_W-1:0]        elem
);
  logic [ELEM_W-1:0] lane_q [N_ELEM];

  for (genvar g = 0; g < N_ELEM; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q[g] <= '0;
      end else if (load) begin
        lane_q[g] <= din[g*ELEM_W +: ELEM_W];
      end
    end
  end

  always_comb begin
    elem = lane_q[0];
    for (int k = 0; k < N_ELEM; k++) begin
      if (sel == SEL_W'(k)) elem = lane_q[k];
    end
  end
endmodule

// File: rtl/s2m_ctrl.sv
// Sequencer: beat intake, per-element write issue, address and count tracking.
module s2m_ctrl
  import s2m_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12,
  parameter int N_ELEM = 4,
  localparam int SEL_W = (N_ELEM > 1) ? $clog2(N_ELEM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_start,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [CNT_W-1:0]  cfg_beats,
  input  logic              s_valid,
  output logic              s_ready,
  output logic              buf_load,
  input  logic              m_waitreq,
  output logic              m_write,
  output logic [ADDR_W-1:0] m_addr,
  output logic [SEL_W-1:0]  elem_sel,
  output logic              done,
  output logic              busy
);
  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(N_ELEM - 1);

  s2m_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic              done_q, done_d;
  logic              take_start, take_beat, take_write;

  always_comb begin
    take_start = (state_q == ST_IDLE) && cfg_start;
    take_beat  = (state_q == ST_RECV) && s_valid;
    take_write = (state_q == ST_WRITE) && !m_waitreq;

    state_d = state_q;
    addr_d  = addr_q;
    left_d  = left_q;
    sel_d   = sel_q;
    done_d  = done_q;

    unique case (state_q)
      ST_IDLE: begin
        if (take_start) begin
          addr_d = cfg_base;
          left_d = cfg_beats;
          sel_d  = '0;
          if (cfg_beats == '0) begin
            done_d = 1'b1;
          end else begin
            done_d  = 1'b0;
            state_d = ST_RECV;
          end
        end
      end
      ST_RECV: begin
        if (take_beat) begin
          sel_d   = '0;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (take_write) begin
          addr_d = addr_q + ADDR_W'(1);
          if (sel_q == LAST_SEL) begin
            sel_d  = '0;
            left_d = left_q - CNT_W'(1);
            if (left_q == CNT_W'(1)) begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end else begin
              state_d = ST_RECV;
            end
          end else begin
            sel_d = sel_q + SEL_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      sel_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      left_q  <= left_d;
      sel_q   <= sel_d;
      done_q  <= done_d;
    end
  end

  assign s_ready  = (state_q == ST_RECV);
  assign buf_load = take_beat;
  assign m_write  = (state_q == ST_WRITE);
  assign m_addr   = addr_q;
  assign elem_sel = sel_q;
  assign done     = done_q;
  assign busy     = (state_q != ST_IDLE);
endmodule

// File: rtl/s2m_unpack_dma.sv
module s2m_unpack_dma #(
  parameter int ELEM_W    = 18,
  parameter int ELEM_FRAC = 10,
  parameter int MEM_W     = 16,
  parameter int MEM_FRAC  = 8,
  parameter int N_ELEM    = 4,
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_start,
  input  logic [ADDR_W-1:0]        cfg_base,
  input  logic [CNT_W-1:0]         cfg_beats,
  input  logic                     s_valid,
  output logic                     s_ready,
  input  logic [N_ELEM*ELEM_W-1:0] s_data,
  input  logic                     s_sop,
  input  logic                     s_eop,
  output logic                     m_write,
  output logic [ADDR_W-1:0]        m_addr,
  output logic [MEM_W-1:0]         m_wdata,
  input  logic                     m_waitreq,
  output logic                     done
);
  localparam int SEL_W = (N_ELEM > 1) ? $clog2(N_ELEM) : 1;

  logic              buf_load;
  logic              busy;
  logic [SEL_W-1:0]  elem_sel;
  logic [ELEM_W-1:0] cur_elem;
  logic              marker_unused;

  assign marker_unused = s_sop ^ s_eop;

  s2m_ctrl #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .N_ELEM (N_ELEM)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_start (cfg_start),
    .cfg_base  (cfg_base),
    .cfg_beats (cfg_beats),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .buf_load  (buf_load),
    .m_waitreq (m_waitreq),
    .m_write   (m_write),
    .m_addr    (m_addr),
    .elem_sel  (elem_sel),
    .done      (done),
    .busy      (busy)
  );

  s2m_beat_buf #(
    .ELEM_W (ELEM_W),
    .N_ELEM (N_ELEM)
  ) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (buf_load),
    .din   (s_data),
    .sel   (elem_sel),
    .elem  (cur_elem)
  );

  s2m_elem_conv #(
    .ELEM_W    (ELEM_W),
    .ELEM_FRAC (ELEM_FRAC),
    .MEM_W     (MEM_W),
    .MEM_FRAC  (MEM_FRAC)
  ) u_conv (
    .elem_in  (cur_elem),
    .word_out (m_wdata)
  );
endmodule

// File: rtl/s2m_unpack_dma_chk.sv
module s2m_unpack_dma_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12,
  parameter int MEM_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_start,
  input logic [CNT_W-1:0]  cfg_beats,
  input logic              busy,
  input logic              s_valid,
  input logic              s_ready,
  input logic              m_write,
  input logic [ADDR_W-1:0] m_addr,
  input logic [MEM_W-1:0]  m_wdata,
  input logic              m_waitreq,
  input logic              done
);
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q  <= '0;
      seen_q <= '0;
    end else if (cfg_start && !busy) begin
      lim_q  <= cfg_beats;
      seen_q <= '0;
    end else if (s_valid && s_ready) begin
      seen_q <= seen_q + CNT_W'(1);
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> (!s_ready && !m_write && !done));

  assert_no_ready_in_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_ready && m_write));

  assert_beat_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |-> (seen_q < lim_q));

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_write && m_waitreq) |=> (m_write && $stable(m_addr) && $stable(m_wdata)));

  assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(m_write && !m_waitreq) || $past(cfg_start)));

  assert_done_not_writing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && m_write));
endmodule

bind s2m_unpack_dma s2m_unpack_dma_chk #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W),
  .MEM_W  (MEM_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_start (cfg_start),
  .cfg_beats (cfg_beats),
  .busy      (busy),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .m_write   (m_write),
  .m_addr    (m_addr),
  .m_wdata   (m_wdata),
  .m_waitreq (m_waitreq),
  .done      (done)
);

// File: tb/s2m_unpack_dma_tb.sv
module s2m_unpack_dma_tb;
  localparam int ELEM_W    = 18;
  localparam int ELEM_FRAC = 10;
  localparam int MEM_W     = 16;
  localparam int MEM_FRAC  = 8;
  localparam int N_ELEM    = 4;
  localparam int ADDR_W    = 16;
  localparam int CNT_W     = 12;

  logic                     clk;
  logic                     rst_n;
  logic                     cfg_start;
  logic [ADDR_W-1:0]        cfg_base;
  logic [CNT_W-1:0]         cfg_beats;
  logic                     s_valid;
  logic                     s_ready;
  logic [N_ELEM*ELEM_W-1:0] s_data;
  logic                     s_sop;
  logic                     s_eop;
  logic                     m_write;
  logic [ADDR_W-1:0]        m_addr;
  logic [MEM_W-1:0]         m_wdata;
  logic                     m_waitreq;
  logic                     done;

  int errors = 0;
  int checks = 0;
  logic [ADDR_W-1:0] q_addr[$];
  logic [MEM_W-1:0]  q_data[$];
  bit   stall_en = 0;
  bit   expect_done = 0;
  logic [15:0] lfsr = 16'hACE1;

  s2m_unpack_dma #(
    .ELEM_W(ELEM_W), .ELEM_FRAC(ELEM_FRAC), .MEM_W(MEM_W), .MEM_FRAC(MEM_FRAC),
    .N_ELEM(N_ELEM), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_base(cfg_base),
    .cfg_beats(cfg_beats), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_sop(s_sop), .s_eop(s_eop), .m_write(m_write), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_waitreq(m_waitreq), .done(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [MEM_W-1:0] ref_conv(input logic [ELEM_W-1:0] raw);
    longint v;
    v = longint'($signed(raw));
    if (MEM_FRAC >= ELEM_FRAC) v = v * (longint'(1) << (MEM_FRAC - ELEM_FRAC));
    else v = v >>> (ELEM_FRAC - MEM_FRAC);
    return MEM_W'(v);
  endfunction

  function automatic logic [ELEM_W-1:0] gen_elem(input int kind, input int i, input int j);
    logic [31:0] h;
    if (kind == 1) begin
      case ((i * N_ELEM + j) % 8)
        0: return {1'b0, {(ELEM_W-1){1'b1}}};
        1: return {1'b1, {(ELEM_W-1){1'b0}}};
        2: return '1;
        3: return ELEM_W'(3);
        4: return -ELEM_W'(3);
        5: return '0;
        6: return ELEM_W'(1 << ELEM_FRAC);
        default: return -ELEM_W'(5 << ELEM_FRAC);
      endcase
    end
    h = 32'(kind * 7919 + i * 131 + j * 977) * 32'd2654435761;
    return h[ELEM_W-1:0];
  endfunction

  // Wait-request driver, off the active edge.
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_waitreq = stall_en && lfsr[0] && (lfsr[3] || lfsr[5]);
  end

  // Monitor: scoreboard pops, stall hold and done timing.
  logic              prev_stall = 0;
  logic [ADDR_W-1:0] prev_addr;
  logic [MEM_W-1:0]  prev_data;
  always @(negedge clk) begin
    if (rst_n) begin
      if (expect_done) begin
        check(done === 1'b1, "R7", "done after last write", done, 1);
        expect_done = 0;
      end
      if (prev_stall) begin
        check(m_write && m_addr == prev_addr && m_wdata == prev_data, "R6",
              "hold under wait-request", m_addr, prev_addr);
      end
      if (m_write) begin
        check(!s_ready, "R2", "ready low while writing", s_ready, 0);
        if (!m_waitreq) begin
          if (q_addr.size() == 0) begin
            check(0, "R3", "unexpected write", m_addr, 0);
          end else begin
            logic [ADDR_W-1:0] ea;
            logic [MEM_W-1:0]  ed;
            ea = q_addr.pop_front();
            ed = q_data.pop_front();
            check(m_addr == ea, "R4", "write address", m_addr, ea);
            check(m_wdata == ed, "R5", "converted data", m_wdata, ed);
            if (q_addr.size() == 0) begin
              check(done === 1'b0, "R7", "done low during last write", done, 0);
              expect_done = 1;
            end
          end
        end
      end
      prev_stall = m_write && m_waitreq;
      prev_addr  = m_addr;
      prev_data  = m_wdata;
    end
  end

  task automatic pulse_start(input logic [ADDR_W-1:0] base, input logic [CNT_W-1:0] n);
    @(negedge clk);
    cfg_base  = base;
    cfg_beats = n;
    cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
  endtask

  // mode 0: sop/eop normal; 1: eop on first beat + restart attempt; 2: no markers
  task automatic run_job(input logic [ADDR_W-1:0] base, input int beats,
                         input int kind, input int mode);
    for (int i = 0; i < beats; i++)
      for (int j = 0; j < N_ELEM; j++) begin
        q_addr.push_back(base + ADDR_W'(i * N_ELEM + j));
        q_data.push_back(ref_conv(gen_elem(kind, i, j)));
      end
    pulse_start(base, CNT_W'(beats));
    check(done === 1'b0, "R7", "done cleared by start", done, 0);
    check(s_ready === 1'b1, "R2", "ready after start", s_ready, 1);
    for (int i = 0; i < beats; i++) begin
      for (int j = 0; j < N_ELEM; j++) s_data[j*ELEM_W +: ELEM_W] = gen_elem(kind, i, j);
      s_sop   = (mode == 0) ? (i == 0) : (mode == 1);
      s_eop   = (mode == 0) ? (i == beats - 1) : (mode == 1 && i == 0);
      s_valid = 1'b1;
      while (s_ready !== 1'b1) @(negedge clk);
      @(negedge clk);
      s_valid = 1'b0;
      s_sop = 1'b0;
      s_eop = 1'b0;
      if (mode == 1 && i == 0) begin
        cfg_base  = base + ADDR_W'(16'h0400);
        cfg_beats = CNT_W'(1);
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
      end
    end
    while (done !== 1'b1) @(negedge clk);
    @(negedge clk);
    check(q_addr.size() == 0, mode == 1 ? "R10" : "R8", "all writes seen",
          q_addr.size(), 0);
    s_valid = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(!s_ready && !m_write, "R3", "idle after last beat", s_ready, 0);
    end
    check(done === 1'b1, "R7", "done sticky", done, 1);
    s_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b1; cfg_start = 0; cfg_base = '0; cfg_beats = '0;
    s_valid = 0; s_data = '0; s_sop = 0; s_eop = 0; m_waitreq = 0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!s_ready && !m_write && !done, "R1", "reset outputs",
          {s_ready, m_write, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!s_ready && !m_write && !done, "R1", "after reset release",
          {s_ready, m_write, done}, 0);

    run_job(16'h0100, 4, 1, 0);        // conversion extremes, no stalls
    stall_en = 1;
    run_job(16'h2000, 6, 5, 0);        // stalled writes
    run_job(16'hFFF8, 3, 7, 2);        // no markers, address wrap
    run_job(16'h0300, 5, 9, 1);        // early eop, restart ignored

    pulse_start(16'h5000, '0);         // R9 zero count
    check(done === 1'b1, "R9", "zero-count done", done, 1);
    check(!s_ready && !m_write, "R9", "no beat or write", {s_ready, m_write}, 0);
    repeat (4) @(negedge clk);
    check(q_addr.size() == 0 && !m_write, "R9", "still idle", m_write, 0);

    stall_en = 0;
    run_job(16'h0040, 2, 1, 2);
    finish_run();
  end
endmodule